// File: doc/BRIEF.md
# Flash Page Program Staging Buffer

This block is the write side of a serial flash memory model. A frame opens when chip select goes low. The frame carries bits, one per strobe. The first 8 bits are a command. The block discards them, because command decoding happens elsewhere. The next 24 bits are the target address, most significant bit first, on lane 0.

Once the address is complete, a page-sized staging buffer logically becomes all ones. Each data byte after that lands at the current byte offset. The offset advances and wraps inside the page, so the page number never changes. Data comes in on one lane, or on four lanes when the quad request is high at the moment the address completes.

When chip select rises after a complete address, the block commits the page. It walks through all offsets and ANDs each staged byte into the matching byte of the addressed page of its internal memory array. Programming can therefore only clear bits. A read port lets the surrounding model inspect the array while no commit is running.

Top module: `flash_page_stager`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `quad_active` are all low.
- R2: A frame starts with 8 discarded command bits and then 24 address bits, most significant first, taken from `dq[0]`. Address bits [MEM_AW-1:8] select the page and bits [7:0] give the starting byte offset. Higher address bits are ignored.
- R3: When the address completes, every staged byte reads as 0xFF. An offset that receives no data leaves its memory byte unchanged at commit.
- R4: Data bytes are stored from the starting offset upward. The offset wraps from 255 to 0 inside the same page. A later byte at an offset already written replaces the earlier one.
- R5: At commit, each memory byte of the addressed page becomes its old value AND the staged byte.
- R6: If `quad_req` is high when the address completes, `quad_active` goes high one cycle later. Each data strobe then carries 4 bits on `dq[3:0]`, with `dq[3]` as the most significant, high nibble first. `quad_active` returns low the cycle after chip select is sampled high.
- R7: A frame that ends before all 32 header bits have arrived starts no commit, and memory is unchanged.
- R8: Call the clock edge at which `cs_n` is first sampled high after a complete address edge C. Then `busy` is high after edges C+1 through C+257. At edge C+258, `busy` falls and `done` pulses high for one cycle.
- R9: Strobes and chip-select activity while `busy` is high are ignored, and a frame sent entirely during a commit writes nothing.
- R10: Bits of a trailing incomplete byte are discarded.
- R11: When `busy` is low at a clock edge, `rd_data` after that edge equals the memory byte at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; a rising level ends the frame |
| bit_stb | input | 1 | One lane sample per high cycle |
| dq | input | 4 | Data lanes; lane 0 alone in single mode |
| quad_req | input | 1 | Selects four-lane data, sampled when the address completes |
| rd_addr | input | MEM_AW | Inspection read address |
| rd_data | output | 8 | Registered memory byte at the previous `rd_addr` |
| busy | output | 1 | Commit walk in progress |
| done | output | 1 | One-cycle pulse when a commit finishes |
| quad_active | output | 1 | Data phase uses four lanes |

## Verification
The bench aims at the offset wrap at the page end and at the 257th byte overwriting offset 0. A design that carried the offset into the next page, or appended past the page, would corrupt the neighbouring page or leave the first byte intact. It also reprograms bytes that already hold data, which exposes a commit that writes instead of ANDs. It sends short frames, trailing partial bytes and a whole frame during a running commit, all of which must leave memory untouched. Quad data frames show whether nibble order or lane-width release after chip select is wrong.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned QUAD_LANES = 4;
  localparam int unsigned BYTE_W     = 8;

  typedef enum logic [1:0] {
    CM_IDLE,
    CM_WALK,
    CM_DRAIN
  } commit_st_e;
endpackage

// File: rtl/fps_rx.sv
// Bit assembler: header counting, address capture, byte assembly.
module fps_rx
  import fps_pkg::*;
#(
  parameter int CMD_BITS = 8,
  parameter int ADDR_W   = 24,
  parameter int KEEP_W   = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  bit_stb,
  input  logic [QUAD_LANES-1:0] dq,
  input  logic                  quad_req,
  output logic                  addr_stb,
  output logic [KEEP_W-1:0]     addr,
  output logic                  byte_stb,
  output logic [BYTE_W-1:0]     byte_q,
  output logic                  frame_end,
  output logic                  quad_active
);
  localparam int HDR_BITS = CMD_BITS + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);

  logic [CNT_W-1:0]  hdr_cnt;
  logic              hdr_done;
  logic [BYTE_W-1:0] bsh;
  logic [2:0]        bpos;

  // addr doubles as the header shift register; it freezes once the header ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_cnt     <= '0;
      hdr_done    <= 1'b0;
      addr        <= '0;
      bsh         <= '0;
      bpos        <= '0;
      addr_stb    <= 1'b0;
      byte_stb    <= 1'b0;
      byte_q      <= '0;
      frame_end   <= 1'b0;
      quad_active <= 1'b0;
    end else begin
      addr_stb  <= 1'b0;
      byte_stb  <= 1'b0;
      frame_end <= 1'b0;
      if (cs_n) begin
        frame_end   <= hdr_done;
        hdr_cnt     <= '0;
        hdr_done    <= 1'b0;
        bpos        <= '0;
        quad_active <= 1'b0;
      end else if (bit_stb) begin
        if (!hdr_done) begin
          addr <= {addr[KEEP_W-2:0], dq[0]};
          if (hdr_cnt == CNT_W'(HDR_BITS - 1)) begin
            hdr_done    <= 1'b1;
            addr_stb    <= 1'b1;
            quad_active <= quad_req;
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end else if (quad_active) begin
          bsh <= {bsh[BYTE_W-QUAD_LANES-1:0], dq};
          if (bpos == 3'd4) begin
            byte_stb <= 1'b1;
            byte_q   <= {bsh[BYTE_W-QUAD_LANES-1:0], dq};
            bpos     <= '0;
          end else begin
            bpos <= bpos + 3'd4;
          end
        end else begin
          bsh <= {bsh[BYTE_W-2:0], dq[0]};
          if (bpos == 3'd7) begin
            byte_stb <= 1'b1;
            byte_q   <= {bsh[BYTE_W-2:0], dq[0]};
            bpos     <= '0;
          end else begin
            bpos <= bpos + 3'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fps_stage.sv
// Page staging buffer: RAM for data plus one fill flag per offset.
module fps_stage
  import fps_pkg::*;
#(
  parameter int PAGE_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr_stb,
  input  logic [PAGE_AW-1:0] start_off,
  input  logic               byte_stb,
  input  logic [BYTE_W-1:0]  byte_d,
  input  logic [PAGE_AW-1:0] rd_idx,
  output logic [BYTE_W-1:0]  rd_byte
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [BYTE_W-1:0]     mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] filled;
  logic [PAGE_AW-1:0]    wr_off;
  logic [BYTE_W-1:0]     raw_q;
  logic                  filled_q;

  // RAM part: no reset, so it maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (byte_stb) mem[wr_off] <= byte_d;
    raw_q <= mem[rd_idx];
  end

  // Flags give the "all ones" state in one cycle instead of a clear walk.
  always_ff @(posedge clk) begin
    if (rst) begin
      filled   <= '0;
      wr_off   <= '0;
      filled_q <= 1'b0;
    end else begin
      filled_q <= filled[rd_idx];
      if (addr_stb) begin
        filled <= '0;
        wr_off <= start_off;
      end else if (byte_stb) begin
        filled[wr_off] <= 1'b1;
        wr_off         <= wr_off + 1'b1;
      end
    end
  end

  assign rd_byte = filled_q ? raw_q : {BYTE_W{1'b1}};
endmodule

// File: rtl/fps_array.sv
// Memory array: one synchronous read port, one write port.
module fps_array
  import fps_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_q,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_d
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = {BYTE_W{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_d;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/flash_page_stager.sv
module flash_page_stager
  import fps_pkg::*;
#(
  parameter int CMD_BITS = 8,
  parameter int ADDR_W   = 24,
  parameter int PAGE_AW  = 8,
  parameter int MEM_AW   = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  bit_stb,
  input  logic [QUAD_LANES-1:0] dq,
  input  logic                  quad_req,
  input  logic [MEM_AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0]     rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  quad_active
);
  localparam int PG_W = MEM_AW - PAGE_AW;

  logic               addr_stb, byte_stb, frame_end;
  logic [MEM_AW-1:0]  hdr_addr;
  logic [BYTE_W-1:0]  byte_q, staged, arr_q;
  logic [PG_W-1:0]    page_r;
  logic [PAGE_AW-1:0] idx, wr_idx;
  logic               wr_pend;
  commit_st_e         st;

  fps_rx #(.CMD_BITS(CMD_BITS), .ADDR_W(ADDR_W), .KEEP_W(MEM_AW)) u_rx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb & ~busy), .dq(dq),
    .quad_req(quad_req), .addr_stb(addr_stb), .addr(hdr_addr),
    .byte_stb(byte_stb), .byte_q(byte_q), .frame_end(frame_end),
    .quad_active(quad_active)
  );

  fps_stage #(.PAGE_AW(PAGE_AW)) u_stage (
    .clk(clk), .rst(rst), .addr_stb(addr_stb),
    .start_off(hdr_addr[PAGE_AW-1:0]), .byte_stb(byte_stb), .byte_d(byte_q),
    .rd_idx(idx), .rd_byte(staged)
  );

  fps_array #(.MEM_AW(MEM_AW)) u_array (
    .clk(clk),
    .rd_addr(busy ? {page_r, idx} : rd_addr),
    .rd_q(arr_q),
    .wr_en(wr_pend),
    .wr_addr({page_r, wr_idx}),
    .wr_d(arr_q & staged)
  );

  assign rd_data = arr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_r <= '0;
    end else if (addr_stb) begin
      page_r <= hdr_addr[MEM_AW-1:PAGE_AW];
    end
  end

  // Commit walk: issue a read per offset, write the AND one cycle later.
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CM_IDLE;
      idx     <= '0;
      wr_idx  <= '0;
      wr_pend <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      wr_pend <= (st == CM_WALK);
      wr_idx  <= idx;
      case (st)
        CM_IDLE: begin
          if (frame_end) begin
            st   <= CM_WALK;
            idx  <= '0;
            busy <= 1'b1;
          end
        end
        CM_WALK: begin
          idx <= idx + 1'b1;
          if (idx == {PAGE_AW{1'b1}}) st <= CM_DRAIN;
        end
        CM_DRAIN: begin
          st   <= CM_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st <= CM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_stager_sva.sv
module flash_page_stager_sva (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic quad_active
);
  // R8: done appears only as busy falls
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  // R8: every busy fall is marked by done
  a_r8_fall_has_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: a commit starts only after chip select was seen high
  a_r8_busy_after_cs: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_n));
  // R6: lane width drops once chip select is high
  a_r6_quad_released: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !quad_active);
endmodule

bind flash_page_stager flash_page_stager_sva u_sva (
  .clk(clk), .rst(rst), .cs_n(cs_n), .busy(busy), .done(done),
  .quad_active(quad_active)
);

// File: tb/tb_flash_page_stager.sv
module tb_flash_page_stager;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       bit_stb = 1'b0;
  logic [3:0] dq = 4'h0;
  logic       quad_req = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done, quad_active;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] txq[$];

  always #10 clk = ~clk;

  flash_page_stager dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb), .dq(dq),
    .quad_req(quad_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .quad_active(quad_active)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_mem [1024];
  logic [7:0]  m_pbuf [256];
  logic [23:0] m_addr;
  logic [7:0]  m_cur, m_rd;
  int  m_nbits, m_off, m_bpos, m_t, m_cpage;
  bit  m_busy, m_done, m_qa, m_rd_ok;

  initial begin
    for (int i = 0; i < 1024; i++) m_mem[i] = 8'hFF;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_nbits = 0; m_off = 0; m_bpos = 0; m_t = -1;
      m_busy = 0; m_done = 0; m_qa = 0; m_rd_ok = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (!was_busy) begin m_rd = m_mem[rd_addr]; m_rd_ok = 1; end
      else m_rd_ok = 0;
      m_done = 0;
      if (m_t >= 0) begin
        m_t++;
        if (m_t == 258) begin
          for (int i = 0; i < 256; i++)
            m_mem[m_cpage*256 + i] = m_mem[m_cpage*256 + i] & m_pbuf[i];
          m_busy = 0; m_done = 1; m_t = -1;
        end else m_busy = 1;
      end
      if (cs_n) begin
        if (m_nbits >= 32) begin m_t = 0; m_cpage = int'(m_addr[9:8]); end
        m_nbits = 0; m_qa = 0; m_bpos = 0;
      end else if (bit_stb && !was_busy) begin
        if (m_nbits < 32) begin
          m_addr = {m_addr[22:0], dq[0]};
          m_nbits++;
          if (m_nbits == 32) begin
            for (int i = 0; i < 256; i++) m_pbuf[i] = 8'hFF;
            m_off = int'(m_addr[7:0]);
            m_qa = quad_req;
          end
        end else begin
          if (m_qa) begin m_cur = {m_cur[3:0], dq}; m_bpos += 4; end
          else begin m_cur = {m_cur[6:0], dq[0]}; m_bpos += 1; end
          if (m_bpos == 8) begin
            m_pbuf[m_off] = m_cur;
            m_off = (m_off + 1) % 256;
            m_bpos = 0;
          end
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      total++;
      if (busy !== m_busy) begin fails++;
        $display("FAIL R8 busy act=%0b exp=%0b t=%0t", busy, m_busy, $time); end
      total++;
      if (done !== m_done) begin fails++;
        $display("FAIL R8 done act=%0b exp=%0b t=%0t", done, m_done, $time); end
      total++;
      if (quad_active !== m_qa) begin fails++;
        $display("FAIL R6 quad_active act=%0b exp=%0b t=%0t", quad_active, m_qa, $time); end
      if (m_rd_ok) begin
        total++;
        if (rd_data !== m_rd) begin fails++;
          $display("FAIL R11 rd_data act=%02h exp=%02h t=%0t", rd_data, m_rd, $time); end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] d);
    bit_stb = 1'b1; dq = d;
    @(negedge clk);
    bit_stb = 1'b0; dq = 4'h0;
  endtask

  task automatic send_frame(input logic [23:0] a, input bit quad, input int extra_bits,
                            input int hdr_bits);
    logic [7:0]  cmd;
    logic [31:0] hdr;
    cmd = quad ? 8'h32 : 8'h02;
    hdr = {cmd, a};
    cs_n = 1'b0; quad_req = quad;
    @(negedge clk);
    for (int i = 31; i >= 32 - hdr_bits; i--) strobe({3'b000, hdr[i]});
    if (hdr_bits == 32) chk("R6 lane mode after header", {7'd0, quad_active}, {7'd0, quad});
    foreach (txq[k]) begin
      if (quad) begin
        strobe(txq[k][7:4]);
        strobe(txq[k][3:0]);
      end else begin
        for (int b = 7; b >= 0; b--) strobe({3'b000, txq[k][b]});
      end
    end
    for (int e = 0; e < extra_bits; e++) strobe(4'h0);
    cs_n = 1'b1; quad_req = 1'b0;
    @(negedge clk);
    txq.delete();
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", total, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);
    chk("R1 done after reset", {7'd0, done}, 8'h00);
    chk("R1 quad_active after reset", {7'd0, quad_active}, 8'h00);

    // R2, R3, R4: single lane, two bytes at offset 0x10
    txq = '{8'hA5, 8'h3C};
    send_frame(24'h000010, 1'b0, 0, 32);
    wait_done();
    rd_chk(10'h010, 8'hA5, "R2 first byte at start offset");
    rd_chk(10'h011, 8'h3C, "R4 second byte");
    rd_chk(10'h012, 8'hFF, "R3 untouched offset above");
    rd_chk(10'h00F, 8'hFF, "R3 untouched offset below");

    // R5: reprogram clears bits only
    txq = '{8'h0F, 8'hF3};
    send_frame(24'hFC0010, 1'b0, 0, 32);
    wait_done();
    rd_chk(10'h010, 8'h05, "R5 AND of A5 and 0F");
    rd_chk(10'h011, 8'h30, "R5 AND of 3C and F3");

    // R4: wrap inside page 1
    txq = '{8'h11, 8'h22, 8'h33};
    send_frame(24'h0001FE, 1'b0, 0, 32);
    wait_done();
    rd_chk(10'h1FE, 8'h11, "R4 byte at FE");
    rd_chk(10'h1FF, 8'h22, "R4 byte at FF");
    rd_chk(10'h100, 8'h33, "R4 wrapped to page start");
    rd_chk(10'h200, 8'hFF, "R4 next page untouched");

    // R4: 257 bytes, last overwrites offset 0
    for (int i = 0; i < 256; i++) txq.push_back(8'(i) ^ 8'h5A);
    txq.push_back(8'h77);
    send_frame(24'h000200, 1'b0, 0, 32);
    wait_done();
    rd_chk(10'h200, 8'h77, "R4 overwrite after full wrap");
    rd_chk(10'h201, 8'h5B, "R4 second byte kept");
    rd_chk(10'h2FF, 8'hA5, "R4 last offset");

    // R6: quad data
    txq = '{8'hC6, 8'h9E};
    send_frame(24'h000380, 1'b1, 0, 32);
    chk("R6 quad_active low after cs", {7'd0, quad_active}, 8'h00);
    wait_done();
    rd_chk(10'h380, 8'hC6, "R6 quad byte 0");
    rd_chk(10'h381, 8'h9E, "R6 quad byte 1");

    // R7: short frame
    txq = '{8'h00};
    send_frame(24'h000300, 1'b0, 0, 20);
    repeat (5) @(negedge clk);
    chk("R7 no commit busy", {7'd0, busy}, 8'h00);
    rd_chk(10'h300, 8'hFF, "R7 memory unchanged");

    // R10: trailing partial byte
    txq = '{8'h00};
    send_frame(24'h000020, 1'b0, 5, 32);
    wait_done();
    rd_chk(10'h020, 8'h00, "R10 full byte stored");
    rd_chk(10'h021, 8'hFF, "R10 partial byte dropped");

    // R9: frame sent during commit
    txq = '{8'h00};
    send_frame(24'h000040, 1'b0, 0, 32);
    repeat (2) @(negedge clk);
    chk("R9 commit running", {7'd0, busy}, 8'h01);
    txq = '{8'h00};
    send_frame(24'h000030, 1'b0, 0, 32);
    wait_done();
    repeat (3) @(negedge clk);
    chk("R9 no second commit", {7'd0, busy}, 8'h00);
    rd_chk(10'h040, 8'h00, "R9 first frame committed");
    rd_chk(10'h030, 8'hFF, "R9 ignored frame wrote nothing");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end
endmodule